// File: doc/BRIEF.md
# Address-Masked GPIO Register Bank

This block is the register file of an eight-pin general-purpose I/O port, sitting on a plain 32-bit bus made of a byte address, a write strobe, write data and a read data bus. Read data is registered and appears on the clock cycle after the address is presented. The bank holds the pin data, the per-pin direction, the interrupt configuration words, a mode-select word and the latched interrupt status. It also answers a read-only identification area. It drives the pin output values and output enables, and it samples the pin inputs through a synchronizer.

Pin data is reached through a 256-word window. The word index inside that window is itself a per-pin mask. A write through the window changes only the pins named by the mask that are also outputs. A read returns only the masked pins. Software can therefore flip single pins without a read-modify-write. Edge and level detection is done by a neighbouring block: this bank hands it the configuration words, takes its per-pin set pulses into the status latch, and lets software read and clear that latch.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero: pinOe and pinOut are 0, all cfg outputs are 0, and every register read returns 0.
- R2: A write to any byte address below 0x400 uses address bits [9:2] as a pin mask (mask bit i is address bit i+2). Data bit i takes write data bit i only when mask bit i and direction bit i are both 1; every other data bit keeps its value.
- R3: A read below 0x400 returns, in bits [7:0], for each pin the data register bit if the pin is an output or the synchronized input if it is an input, ANDed with the address mask; all other bits are 0. Any read result appears on busRData one cycle after the address.
- R4: Writes to the byte addresses 0x400 (direction), 0x404 (sense), 0x408 (both-edges), 0x40C (event polarity), 0x410 (interrupt enable) and 0x420 (mode select) store write data bits [7:0]. A read of the same address returns that value with bits [31:8] zero, and the matching cfg output shows it.
- R5: pinOe equals the direction register (1 = output) and pinOut equals the data register.
- R6: Input pins pass through a two-stage synchronizer. A read whose address is presented in the same cycle as an input change still returns the old value; the new value is returned from three cycles after the change.
- R7: A 1 on irqSet bit i latches raw status bit i. The raw status is read at 0x414. The read at 0x418 returns raw status ANDed with the interrupt enable register.
- R8: A write to 0x41C clears each raw status bit whose write data bit is 1. If irqSet sets a bit in the same cycle, the set wins.
- R9: The eight words 0xFE0, 0xFE4, ... 0xFFC read, in address order, 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with bits [31:8] zero.
- R10: Reads of 0x41C and of any unmapped address return 0. Writes to unmapped addresses, the identification area, 0x414 and 0x418 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWrite | input | 1 | Write strobe, one access per cycle |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Registered read data, valid one cycle after busAddr |
| pinIn | input | 8 | Asynchronous pin inputs |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables |
| irqSet | input | 8 | Per-pin set pulses from the interrupt detector |
| cfgSense | output | 8 | Level (1) or edge (0) detection per pin |
| cfgBothEdge | output | 8 | Detect both edges per pin |
| cfgRiseHigh | output | 8 | Rising edge / high level polarity per pin |
| cfgIrqEn | output | 8 | Interrupt enable per pin |
| cfgAltMode | output | 8 | Mode select per pin |

## Verification
A corrupted direction or data bit shows at pinOe or pinOut on the cycle after the write that caused it, and through the masked data window on the following read. A wrong mask decode reveals itself as a pin that moves, or fails to move, when only its neighbours were addressed, which is why random window addresses are mixed with output/input mixes. Faults in the status latch only surface on a raw or masked status read, so those reads follow every set pulse and clear write, including the cycle where both meet.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS   = 8;
  localparam int ADDR_W = 12;

  localparam logic [9:0] WORD_DIR    = 10'h100;
  localparam logic [9:0] WORD_SENSE  = 10'h101;
  localparam logic [9:0] WORD_BOTH   = 10'h102;
  localparam logic [9:0] WORD_EVENT  = 10'h103;
  localparam logic [9:0] WORD_ENABLE = 10'h104;
  localparam logic [9:0] WORD_RAW    = 10'h105;
  localparam logic [9:0] WORD_MASKED = 10'h106;
  localparam logic [9:0] WORD_CLEAR  = 10'h107;
  localparam logic [9:0] WORD_MODE   = 10'h108;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_EVENT,
    RD_ENABLE, RD_RAW, RD_MASKED, RD_MODE, RD_ID
  } readSel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrEnable;
    logic wrClear;
    logic wrMode;
    readSel_e rdSel;
    logic [PINS-1:0] mask;
    logic [2:0] idIdx;
  } strobes_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h61;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output strobes_t          strb
);
  logic [ADDR_W-3:0] wordIdx;
  logic inWindow;
  logic inId;

  assign wordIdx  = busAddr[ADDR_W-1:2];
  assign inWindow = (busAddr[ADDR_W-1:10] == '0);
  assign inId     = (busAddr[ADDR_W-1:5] == '1);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    strb.mask  = busAddr[PINS+1:2];
    strb.idIdx = busAddr[4:2];
    if (inWindow) begin
      strb.rdSel  = RD_DATA;
      strb.wrData = busWrite;
    end else if (inId) begin
      strb.rdSel = RD_ID;
    end else begin
      case (wordIdx)
        WORD_DIR:    begin strb.rdSel = RD_DIR;    strb.wrDir    = busWrite; end
        WORD_SENSE:  begin strb.rdSel = RD_SENSE;  strb.wrSense  = busWrite; end
        WORD_BOTH:   begin strb.rdSel = RD_BOTH;   strb.wrBoth   = busWrite; end
        WORD_EVENT:  begin strb.rdSel = RD_EVENT;  strb.wrEvent  = busWrite; end
        WORD_ENABLE: begin strb.rdSel = RD_ENABLE; strb.wrEnable = busWrite; end
        WORD_RAW:    strb.rdSel = RD_RAW;
        WORD_MASKED: strb.rdSel = RD_MASKED;
        WORD_CLEAR:  strb.wrClear = busWrite;
        WORD_MODE:   begin strb.rdSel = RD_MODE;   strb.wrMode   = busWrite; end
        default: ;
      endcase
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.wrSense, strb.wrBoth, strb.wrEvent,
              strb.wrEnable, strb.wrClear, strb.wrMode})); // R4
  AST_NO_STROBE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |-> ({strb.wrData, strb.wrDir, strb.wrSense, strb.wrBoth, strb.wrEvent,
                    strb.wrEnable, strb.wrClear, strb.wrMode} == '0)); // R10
  AST_ID_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:5] == '1) |-> ({strb.wrData, strb.wrDir, strb.wrSense, strb.wrBoth,
      strb.wrEvent, strb.wrEnable, strb.wrClear, strb.wrMode} == '0)); // R10
endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wData,
  input  logic [PINS-1:0]   pinIn,
  input  logic [PINS-1:0]   irqSet,
  output logic [DATA_W-1:0] rData,
  output logic [PINS-1:0]   dataReg,
  output logic [PINS-1:0]   dirReg,
  output logic [PINS-1:0]   senseReg,
  output logic [PINS-1:0]   bothReg,
  output logic [PINS-1:0]   eventReg,
  output logic [PINS-1:0]   enableReg,
  output logic [PINS-1:0]   modeReg
);
  logic [PINS-1:0] rawSt;
  logic [PINS-1:0] syncChain [SYNC_STAGES];
  logic [PINS-1:0] pinSync;
  logic [PINS-1:0] writeMask;
  logic [PINS-1:0] pinView;
  logic [PINS-1:0] rdByte;
  logic [PINS-1:0] wByte;

  assign wByte = wData[PINS-1:0];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= pinIn;
      else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end
  assign pinSync = syncChain[SYNC_STAGES-1];

  assign writeMask = strb.mask & dirReg;
  assign pinView   = (dirReg & dataReg) | (~dirReg & pinSync);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0; dirReg <= '0; senseReg <= '0; bothReg <= '0;
      eventReg <= '0; enableReg <= '0; modeReg <= '0; rawSt <= '0;
    end else begin
      if (strb.wrData)   dataReg   <= (dataReg & ~writeMask) | (wByte & writeMask);
      if (strb.wrDir)    dirReg    <= wByte;
      if (strb.wrSense)  senseReg  <= wByte;
      if (strb.wrBoth)   bothReg   <= wByte;
      if (strb.wrEvent)  eventReg  <= wByte;
      if (strb.wrEnable) enableReg <= wByte;
      if (strb.wrMode)   modeReg   <= wByte;
      rawSt <= ((strb.wrClear ? (rawSt & ~wByte) : rawSt)) | irqSet;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_DATA:   rdByte = pinView & strb.mask;
      RD_DIR:    rdByte = dirReg;
      RD_SENSE:  rdByte = senseReg;
      RD_BOTH:   rdByte = bothReg;
      RD_EVENT:  rdByte = eventReg;
      RD_ENABLE: rdByte = enableReg;
      RD_RAW:    rdByte = rawSt;
      RD_MASKED: rdByte = rawSt & enableReg;
      RD_MODE:   rdByte = modeReg;
      RD_ID:     rdByte = idByte(strb.idIdx);
      default:   rdByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rData <= '0;
    else rData <= DATA_W'(rdByte);
  end

  AST_DATA_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> $stable(dataReg)); // R2
  AST_DATA_HOLD_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (((dataReg ^ $past(dataReg)) & ~$past(strb.mask & dirReg)) == '0)); // R2
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg)); // R4
  AST_RAW_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rstN)
    (irqSet == '0) |=> ((rawSt & ~$past(rawSt)) == '0)); // R7
  AST_RAW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (irqSet != '0) |=> ((rawSt & $past(irqSet)) == $past(irqSet))); // R8
  AST_RAW_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClear && irqSet == '0) |=> ((rawSt & $past(wByte)) == '0)); // R8
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  input  logic [PINS-1:0]   irqSet,
  output logic [PINS-1:0]   cfgSense,
  output logic [PINS-1:0]   cfgBothEdge,
  output logic [PINS-1:0]   cfgRiseHigh,
  output logic [PINS-1:0]   cfgIrqEn,
  output logic [PINS-1:0]   cfgAltMode
);
  strobes_t strb;
  logic [PINS-1:0] dataReg;
  logic [PINS-1:0] dirReg;

  gpio_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite), .strb(strb)
  );

  gpio_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(busWData), .pinIn(pinIn),
    .irqSet(irqSet), .rData(busRData), .dataReg(dataReg), .dirReg(dirReg),
    .senseReg(cfgSense), .bothReg(cfgBothEdge), .eventReg(cfgRiseHigh),
    .enableReg(cfgIrqEn), .modeReg(cfgAltMode)
  );

  assign pinOut = dataReg;
  assign pinOe  = dirReg;

  AST_INPUT_PIN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr[ADDR_W-1:10] == '0) |=>
      (((pinOut ^ $past(pinOut)) & ~$past(pinOe)) == '0)); // R2
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic busWrite = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [7:0] pinIn = '0, pinOut, pinOe, irqSet = '0;
  logic [7:0] cfgSense, cfgBothEdge, cfgRiseHigh, cfgIrqEn, cfgAltMode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] mData = 0, mDir = 0, mSense = 0, mBoth = 0, mEvt = 0, mEn = 0, mRaw = 0, mMode = 0, mPin = 0;

  always #10 clk = ~clk;

  gpio_bank i_gpio_bank (.*);

  function automatic logic [7:0] idRef(input int k);
    logic [7:0] t [8] = '{8'h61, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [7:0] m = a[9:2];
    if (a < 12'h400) return {24'h0, ((mDir & mData) | (~mDir & mPin)) & m};
    if (a >= 12'hFE0) return {24'h0, idRef(int'(a[4:2]))};
    case (a[11:2])
      10'h100: return {24'h0, mDir};
      10'h101: return {24'h0, mSense};
      10'h102: return {24'h0, mBoth};
      10'h103: return {24'h0, mEvt};
      10'h104: return {24'h0, mEn};
      10'h105: return {24'h0, mRaw};
      10'h106: return {24'h0, mRaw & mEn};
      10'h108: return {24'h0, mMode};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check({req, " pinOut"}, {24'h0, pinOut}, {24'h0, mData});
    check({req, " pinOe"}, {24'h0, pinOe}, {24'h0, mDir});
    check({req, " cfg"}, {cfgSense, cfgBothEdge, cfgRiseHigh, cfgIrqEn},
          {mSense, mBoth, mEvt, mEn});
    check({req, " mode"}, {24'h0, cfgAltMode}, {24'h0, mMode});
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, input logic [7:0] irq);
    logic [7:0] m;
    @(negedge clk);
    busAddr = a; busWrite = 1'b1; busWData = d; irqSet = irq;
    @(negedge clk);
    busWrite = 1'b0; irqSet = '0;
    if (a < 12'h400) begin
      m = a[9:2] & mDir;
      mData = (mData & ~m) | (d[7:0] & m);
    end else if (a < 12'hFE0) begin
      case (a[11:2])
        10'h100: mDir = d[7:0];
        10'h101: mSense = d[7:0];
        10'h102: mBoth = d[7:0];
        10'h103: mEvt = d[7:0];
        10'h104: mEn = d[7:0];
        10'h107: mRaw = mRaw & ~d[7:0];
        10'h108: mMode = d[7:0];
        default: ;
      endcase
    end
    mRaw = mRaw | irq;
  endtask

  task automatic doRead(input logic [11:0] a, input string req);
    @(negedge clk);
    busAddr = a; busWrite = 1'b0;
    @(negedge clk);
    check(req, busRData, expRead(a));
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    pinIn = v; mPin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseIrq(input logic [7:0] v);
    @(negedge clk);
    irqSet = v;
    @(negedge clk);
    irqSet = '0; mRaw = mRaw | v;
  endtask

  function automatic logic [11:0] randAddr();
    int k = int'($urandom_range(0, 3));
    case (k)
      0: return 12'($urandom_range(0, 255) * 4);
      1: return 12'h400 + 12'($urandom_range(0, 8) * 4);
      2: return 12'h424 + 12'($urandom_range(0, 700) * 4);
      default: return 12'hFE0 + 12'($urandom_range(0, 7) * 4);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkOutputs("R1");
    doRead(12'h400, "R1 dir read");
    doRead(12'h414, "R1 raw read");
    doRead(12'h3FC, "R1 window read");

    // R4: configuration registers, upper bits dropped
    doWrite(12'h400, 32'hFFFF_FF0F, 0); checkOutputs("R4 dir");
    doRead(12'h400, "R4 dir readback");
    doWrite(12'h404, 32'h1234_5633, 0); doRead(12'h404, "R4 sense");
    doWrite(12'h408, 32'hAA, 0); doRead(12'h408, "R4 both");
    doWrite(12'h40C, 32'h55, 0); doRead(12'h40C, "R4 event");
    doWrite(12'h410, 32'h0F0, 0); doRead(12'h410, "R4 enable");
    doWrite(12'h420, 32'hC3, 0); doRead(12'h420, "R4 mode");
    checkOutputs("R4 outputs");

    // R2/R5: masked write, input pins untouched
    doWrite(12'h3FC, 32'hFF, 0); checkOutputs("R2 full mask R5");
    doWrite(12'h004 | 12'h010, 32'h00, 0); checkOutputs("R2 partial mask");
    doWrite(12'h000, 32'h00, 0); checkOutputs("R2 zero mask");
    doWrite(12'h3FC, 32'hF0, 0);
    check("R2 input pins hold", {24'h0, pinOut & 8'hF0}, 32'h0);

    // R3/R6: mixed read, synchronizer latency
    setPins(8'hA5);
    doRead(12'h3FC, "R3 mixed read");
    doRead(12'h0A8, "R3 masked read");
    @(negedge clk);
    pinIn = 8'h5A; busAddr = 12'h3FC; busWrite = 1'b0;
    @(negedge clk);
    check("R6 old value during sync", busRData, {24'h0, (mDir & mData) | (~mDir & 8'hA5)});
    mPin = 8'h5A;
    repeat (2) @(negedge clk);
    check("R6 new value after sync", busRData, expRead(12'h3FC));

    // R7/R8: status latch, mask, clear, set wins
    pulseIrq(8'h3C);
    doRead(12'h414, "R7 raw");
    doRead(12'h418, "R7 masked");
    doWrite(12'h41C, 32'h0C, 0); doRead(12'h414, "R8 clear");
    doWrite(12'h41C, 32'hFF, 8'h81); doRead(12'h414, "R8 set wins");

    // R9: identification bytes
    for (int k = 0; k < 8; k++) doRead(12'hFE0 + 12'(k * 4), "R9 id");

    // R10: ignored writes and zero reads
    doWrite(12'hFE0, 32'hFFFF_FFFF, 0);
    doWrite(12'h424, 32'hFFFF_FFFF, 0);
    doWrite(12'h414, 32'hFF, 0);
    doWrite(12'h418, 32'hFF, 0);
    checkOutputs("R10 ignored writes");
    doRead(12'h414, "R10 raw unchanged");
    doRead(12'h41C, "R10 clear reads zero");
    doRead(12'h800, "R10 reserved zero");
    doRead(12'hFE0, "R10 id unchanged");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 4) begin
        doWrite(randAddr(), $urandom(), (op == 0) ? 8'($urandom) : 8'h0);
        checkOutputs("R2 R4 R5 random write");
      end else if (op < 8) doRead(randAddr(), "R3 R7 R9 R10 random read");
      else if (op == 8) setPins(8'($urandom));
      else pulseIrq(8'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule